// File: doc/BRIEF.md
# Command line receive buffer

This block gathers incoming characters into a small on-chip buffer until an end-of-command character shows up, and then hands back the words of that command one at a time. Each arriving character comes with a one-cycle valid strobe. Characters whose code falls below a programmable floor are consumed but not kept, which strips control codes out of a typed line. The end-of-command character is stored as a zero byte, and one slot is always kept free for it. Once the command is complete the buffer is frozen, and everything that arrives afterwards is thrown away until the command is cleared.

When the command is complete, the consumer pulses a request for the next parameter. A small scanner then walks the stored bytes, one per clock, from where the last search stopped. Runs of the separator character are skipped. The scanner answers with either a one-cycle found pulse, which carries the buffer index of the first character and the length of the word, or a one-cycle none-left pulse. A clear strobe empties the buffer, rewinds the scanner and drops every flag, so the next command starts at index 0.

Top module: `cmdline_buffer`

## Requirements
- R1: A valid character equal to `term_char` completes the command. `cmd_ready` reads 1 from the next cycle and a zero byte is stored in place of the terminator. The terminator test comes before the threshold test, so a terminator whose code is below `ignore_below` still completes the command.
- R2: While `cmd_ready` is 1, every incoming character, terminators included, is discarded. The stored command and its parameters do not change until `cmd_clear`.
- R3: With a buffer of DEPTH bytes, at most DEPTH-1 characters are stored, and a parameter of length DEPTH-1 starting at index 0 can be returned.
- R4: A non-terminator character whose unsigned code is below `ignore_below` is consumed without being stored, and later characters close the gap.
- R5: A storable character that arrives when DEPTH-1 characters are already held is dropped, and `overflow` rises in the next cycle. `overflow` stays 1 until `cmd_clear`.
- R6: A `param_req` pulse while `cmd_ready` is 1 and no search is running starts a search. The search ends with a one-cycle `param_valid` pulse. During that pulse, `param_start` holds the 0-based buffer index of the word's first character and `param_len` holds its length. Successive requests return the words from left to right.
- R7: Leading, trailing and repeated `delim_char` bytes are skipped, so a returned parameter always has `param_len` of at least 1.
- R8: When no word remains, the search ends with a one-cycle `param_none` pulse instead. Every later request also ends with `param_none`.
- R9: `cmd_clear` zeroes the write position, the search position, `cmd_ready`, `overflow` and any running search. It takes priority over a character offered in the same cycle, which is dropped.
- R10: A `param_req` while `cmd_ready` is 0, or while a search is running, is ignored: no pulse results from it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| rx_valid | input | 1 | A character is offered this cycle |
| rx_char | input | 8 | Offered character |
| term_char | input | 8 | End-of-command character |
| delim_char | input | 8 | Parameter separator |
| ignore_below | input | 8 | Characters with a lower code are not stored |
| param_req | input | 1 | Request the next parameter |
| cmd_clear | input | 1 | Discard the command and rewind |
| cmd_ready | output | 1 | A complete command is held |
| overflow | output | 1 | A character was dropped for lack of room |
| param_valid | output | 1 | One-cycle pulse: a parameter was found |
| param_none | output | 1 | One-cycle pulse: no parameter remains |
| param_start | output | $clog2(DEPTH) | Buffer index of the parameter's first character |
| param_len | output | $clog2(DEPTH) | Length of the parameter |

## Verification
Two events can land in the same cycle: a clear and an offered character. The bench raises `cmd_clear` and `rx_valid` together, with a printable character on the bus. It then checks that `cmd_ready` and `overflow` both read 0. Next it sends a short command and requests its first parameter. The result must start at index 0 with the command's own length, which proves the clear won and the colliding character never reached the buffer. A terminator arriving together with a parameter request is judged the same way: the request must produce no pulse.

// File: rtl/cmdbuf_pkg.sv
package cmdbuf_pkg;
    localparam int CHAR_W = 8;

    typedef enum logic [1:0] {
        SC_IDLE = 2'd0,
        SC_SKIP = 2'd1,
        SC_TAKE = 2'd2
    } scan_state_e;
endpackage

// File: rtl/cmdbuf_store.sv
module cmdbuf_store
    import cmdbuf_pkg::*;
#(
    parameter int DEPTH = 16
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       rx_valid,
    input  logic [CHAR_W-1:0]          rx_char,
    input  logic [CHAR_W-1:0]          term_char,
    input  logic [CHAR_W-1:0]          ignore_below,
    input  logic                       cmd_clear,
    input  logic [$clog2(DEPTH)-1:0]   rd_addr,
    output logic [CHAR_W-1:0]          rd_data,
    output logic                       cmd_ready,
    output logic                       overflow
);
    localparam int AW = $clog2(DEPTH);
    localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);

    typedef struct packed {
        logic [AW-1:0] wr_ptr;
        logic          ready;
        logic          ovf;
    } store_t;

    store_t             st_d, st_q;
    logic               we;
    logic [CHAR_W-1:0]  wdata;
    logic [CHAR_W-1:0]  mem_q [DEPTH];

    always_comb begin
        st_d  = st_q;
        we    = 1'b0;
        wdata = '0;
        if (cmd_clear) begin
            st_d = '0;
        end else if (rx_valid && !st_q.ready) begin
            if (rx_char == term_char) begin
                we       = 1'b1;
                wdata    = '0;
                st_d.ready = 1'b1;
            end else if (rx_char < ignore_below) begin
                st_d = st_q;
            end else if (st_q.wr_ptr == LAST) begin
                st_d.ovf = 1'b1;
            end else begin
                we          = 1'b1;
                wdata       = rx_char;
                st_d.wr_ptr = st_q.wr_ptr + 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    always_ff @(posedge clk) begin
        if (we) mem_q[st_q.wr_ptr] <= wdata;
    end

    assign rd_data   = mem_q[rd_addr];
    assign cmd_ready = st_q.ready;
    assign overflow  = st_q.ovf;

    p_term_sets_ready_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_valid && !cmd_clear && !cmd_ready && rx_char == term_char) |=> cmd_ready);

    p_frozen_after_term_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_ready && !cmd_clear) |=> (cmd_ready && $stable(st_q.wr_ptr)));

    p_filtered_not_stored_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_valid && !cmd_clear && rx_char != term_char && rx_char < ignore_below)
        |=> $stable(st_q.wr_ptr));

    p_no_overflow_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_valid && !cmd_clear && !cmd_ready && rx_char != term_char &&
         rx_char >= ignore_below && st_q.wr_ptr == LAST)
        |=> (overflow && $stable(st_q.wr_ptr)));

    p_room_bound_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.wr_ptr == LAST && !cmd_clear) |=> (st_q.wr_ptr == LAST));

    p_clear_empties_r9: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_clear |=> (st_q.wr_ptr == '0 && !cmd_ready && !overflow));
endmodule

// File: rtl/cmdbuf_scan.sv
module cmdbuf_scan
    import cmdbuf_pkg::*;
#(
    parameter int DEPTH = 16
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       cmd_ready,
    input  logic                       cmd_clear,
    input  logic                       param_req,
    input  logic [CHAR_W-1:0]          delim_char,
    input  logic [CHAR_W-1:0]          rd_data,
    output logic [$clog2(DEPTH)-1:0]   rd_addr,
    output logic                       param_valid,
    output logic                       param_none,
    output logic [$clog2(DEPTH)-1:0]   param_start,
    output logic [$clog2(DEPTH)-1:0]   param_len
);
    localparam int AW = $clog2(DEPTH);

    typedef struct packed {
        scan_state_e   state;
        logic [AW-1:0] pos;
        logic [AW-1:0] start;
        logic [AW-1:0] len;
        logic          found;
        logic          none;
    } scan_t;

    scan_t sc_d, sc_q;
    logic  at_end;
    logic  at_delim;

    assign at_end   = (rd_data == '0);
    assign at_delim = (rd_data == delim_char);

    always_comb begin
        sc_d       = sc_q;
        sc_d.found = 1'b0;
        sc_d.none  = 1'b0;
        if (cmd_clear) begin
            sc_d = '0;
        end else begin
            unique case (sc_q.state)
                SC_IDLE: begin
                    if (param_req && cmd_ready) sc_d.state = SC_SKIP;
                end
                SC_SKIP: begin
                    if (at_end) begin
                        sc_d.none  = 1'b1;
                        sc_d.state = SC_IDLE;
                    end else if (at_delim) begin
                        sc_d.pos = sc_q.pos + 1'b1;
                    end else begin
                        sc_d.start = sc_q.pos;
                        sc_d.len   = AW'(1);
                        sc_d.pos   = sc_q.pos + 1'b1;
                        sc_d.state = SC_TAKE;
                    end
                end
                SC_TAKE: begin
                    if (at_end || at_delim) begin
                        sc_d.found = 1'b1;
                        sc_d.state = SC_IDLE;
                    end else begin
                        sc_d.len = sc_q.len + 1'b1;
                        sc_d.pos = sc_q.pos + 1'b1;
                    end
                end
                default: sc_d.state = SC_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sc_q <= '0;
        else        sc_q <= sc_d;
    end

    assign rd_addr     = sc_q.pos;
    assign param_valid = sc_q.found;
    assign param_none  = sc_q.none;
    assign param_start = sc_q.start;
    assign param_len   = sc_q.len;

    p_nonempty_param_r7: assert property (@(posedge clk) disable iff (!rst_n)
        param_valid |-> (param_len != '0));

    p_single_outcome_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !(param_valid && param_none));

    p_req_ignored_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (sc_q.state == SC_IDLE && param_req && !cmd_ready) |=> (sc_q.state == SC_IDLE));

    p_search_starts_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (sc_q.state == SC_IDLE && param_req && cmd_ready && !cmd_clear) |=> (sc_q.state == SC_SKIP));

    p_clear_rewinds_r9: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_clear |=> (sc_q.state == SC_IDLE && sc_q.pos == '0 && !param_valid && !param_none));
endmodule

// File: rtl/cmdline_buffer.sv
module cmdline_buffer
    import cmdbuf_pkg::*;
#(
    parameter int DEPTH = 16
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       rx_valid,
    input  logic [7:0]                 rx_char,
    input  logic [7:0]                 term_char,
    input  logic [7:0]                 delim_char,
    input  logic [7:0]                 ignore_below,
    input  logic                       param_req,
    input  logic                       cmd_clear,
    output logic                       cmd_ready,
    output logic                       overflow,
    output logic                       param_valid,
    output logic                       param_none,
    output logic [$clog2(DEPTH)-1:0]   param_start,
    output logic [$clog2(DEPTH)-1:0]   param_len
);
    localparam int AW = $clog2(DEPTH);

    logic [AW-1:0]     rd_addr;
    logic [CHAR_W-1:0] rd_data;

    cmdbuf_store #(.DEPTH(DEPTH)) u_store (
        .clk          (clk),
        .rst_n        (rst_n),
        .rx_valid     (rx_valid),
        .rx_char      (rx_char),
        .term_char    (term_char),
        .ignore_below (ignore_below),
        .cmd_clear    (cmd_clear),
        .rd_addr      (rd_addr),
        .rd_data      (rd_data),
        .cmd_ready    (cmd_ready),
        .overflow     (overflow)
    );

    cmdbuf_scan #(.DEPTH(DEPTH)) u_scan (
        .clk         (clk),
        .rst_n       (rst_n),
        .cmd_ready   (cmd_ready),
        .cmd_clear   (cmd_clear),
        .param_req   (param_req),
        .delim_char  (delim_char),
        .rd_data     (rd_data),
        .rd_addr     (rd_addr),
        .param_valid (param_valid),
        .param_none  (param_none),
        .param_start (param_start),
        .param_len   (param_len)
    );
endmodule

// File: tb/cmdline_buffer_tb.sv
module cmdline_buffer_tb;
    localparam int DEPTH = 16;
    localparam int AW    = $clog2(DEPTH);

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic rx_valid = 1'b0;
    logic [7:0] rx_char = '0;
    logic [7:0] term_char = 8'h0D;
    logic [7:0] delim_char = 8'h20;
    logic [7:0] ignore_below = 8'h20;
    logic param_req = 1'b0;
    logic cmd_clear = 1'b0;
    logic cmd_ready, overflow, param_valid, param_none;
    logic [AW-1:0] param_start, param_len;

    int checks = 0;
    int failures = 0;

    always #2.5 clk = ~clk;

    cmdline_buffer #(.DEPTH(DEPTH)) u_dut (
        .clk(clk), .rst_n(rst_n), .rx_valid(rx_valid), .rx_char(rx_char),
        .term_char(term_char), .delim_char(delim_char), .ignore_below(ignore_below),
        .param_req(param_req), .cmd_clear(cmd_clear), .cmd_ready(cmd_ready),
        .overflow(overflow), .param_valid(param_valid), .param_none(param_none),
        .param_start(param_start), .param_len(param_len)
    );

    // Table entries: {found, start[7:0], len[7:0]} for "cmd  foo bar c"
    localparam logic [16:0] EXP_TAB [5] = '{
        {1'b1, 8'd0,  8'd3},
        {1'b1, 8'd5,  8'd3},
        {1'b1, 8'd9,  8'd3},
        {1'b1, 8'd13, 8'd1},
        {1'b0, 8'd0,  8'd0}
    };

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic send_char(input logic [7:0] c);
        @(negedge clk);
        rx_valid = 1'b1;
        rx_char  = c;
        @(negedge clk);
        rx_valid = 1'b0;
    endtask

    task automatic send_str(input string s);
        for (int i = 0; i < s.len(); i++) send_char(s[i]);
    endtask

    task automatic do_clear();
        @(negedge clk);
        cmd_clear = 1'b1;
        @(negedge clk);
        cmd_clear = 1'b0;
    endtask

    // result: -1 = no pulse, 0 = none, 1 = found
    task automatic get_param(output int res, output int st, output int ln);
        res = -1; st = 0; ln = 0;
        @(negedge clk);
        param_req = 1'b1;
        @(negedge clk);
        param_req = 1'b0;
        for (int k = 0; k < 40; k++) begin
            @(negedge clk);
            if (param_valid) begin
                res = 1; st = int'(param_start); ln = int'(param_len);
                break;
            end
            if (param_none) begin
                res = 0;
                break;
            end
        end
    endtask

    initial begin
        #250000;
        failures++;
        $display("FAIL watchdog actual=expired expected=done");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        int res, st, ln;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // reset state
        chk("reset cmd_ready", int'(cmd_ready), 0);
        chk("reset overflow", int'(overflow), 0);
        chk("reset pulses", int'(param_valid | param_none), 0);

        // R10: request before command is complete gives no pulse
        get_param(res, st, ln);
        chk("R10 req while not ready", res, -1);

        // Vector table walk, R6 R7 R8 R1
        send_str("cmd  foo bar c");
        chk("R1 not ready before terminator", int'(cmd_ready), 0);
        send_char(8'h0D);
        chk("R1 ready after terminator", int'(cmd_ready), 1);
        for (int i = 0; i < 5; i++) begin
            get_param(res, st, ln);
            chk("R6 table found", res, int'(EXP_TAB[i][16]));
            if (EXP_TAB[i][16]) begin
                chk("R6 table start", st, int'(EXP_TAB[i][15:8]));
                chk("R7 table len", ln, int'(EXP_TAB[i][7:0]));
            end
        end
        get_param(res, st, ln);
        chk("R8 none repeats", res, 0);

        // R4 filter, R2 frozen after terminator
        do_clear();
        send_char("a");
        send_char(8'h05);
        send_char("b");
        send_char(8'h0D);
        send_str("xyz");
        send_char(8'h0D);
        chk("R2 still ready", int'(cmd_ready), 1);
        get_param(res, st, ln);
        chk("R4 filtered found", res, 1);
        chk("R4 filtered len", ln, 2);
        get_param(res, st, ln);
        chk("R2 no trailing chars", res, 0);

        // R3 capacity and R5 overflow
        do_clear();
        for (int i = 0; i < DEPTH - 1; i++) send_char("k");
        chk("R3 no overflow at capacity", int'(overflow), 0);
        send_char("q");
        chk("R5 overflow set", int'(overflow), 1);
        send_char(8'h0D);
        chk("R5 overflow held", int'(overflow), 1);
        get_param(res, st, ln);
        chk("R3 full word start", st, 0);
        chk("R3 full word len", ln, DEPTH - 1);
        get_param(res, st, ln);
        chk("R5 dropped char absent", res, 0);

        // R9 clear collides with an offered character
        @(negedge clk);
        cmd_clear = 1'b1;
        rx_valid  = 1'b1;
        rx_char   = "z";
        @(negedge clk);
        cmd_clear = 1'b0;
        rx_valid  = 1'b0;
        chk("R9 ready cleared", int'(cmd_ready), 0);
        chk("R9 overflow cleared", int'(overflow), 0);
        send_str("hi");
        send_char(8'h0D);
        get_param(res, st, ln);
        chk("R9 start at zero", st, 0);
        chk("R9 colliding char dropped", ln, 2);

        // R7 other delimiter, leading and repeated separators; clear mid-walk
        do_clear();
        delim_char = ",";
        send_str(",,a,,bc,");
        send_char(8'h0D);
        get_param(res, st, ln);
        chk("R7 leading skip start", st, 2);
        chk("R7 leading skip len", ln, 1);
        get_param(res, st, ln);
        chk("R7 repeated skip start", st, 5);
        chk("R7 repeated skip len", ln, 2);
        get_param(res, st, ln);
        chk("R7 trailing delim none", res, 0);

        do_clear();
        send_str("p,q");
        send_char(8'h0D);
        get_param(res, st, ln);
        do_clear();
        send_str("rs");
        // R10: terminator and request in the same cycle
        @(negedge clk);
        rx_valid = 1'b1; rx_char = 8'h0D; param_req = 1'b1;
        @(negedge clk);
        rx_valid = 1'b0; param_req = 1'b0;
        repeat (10) begin
            @(negedge clk);
            if (param_valid | param_none) begin
                chk("R10 req with terminator ignored", 1, 0);
            end
        end
        get_param(res, st, ln);
        chk("R9 search rewound start", st, 0);
        chk("R9 search rewound len", ln, 2);

        // R1 empty command
        do_clear();
        send_char(8'h0D);
        chk("R1 empty ready", int'(cmd_ready), 1);
        get_param(res, st, ln);
        chk("R8 empty none", res, 0);

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule